// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. It has two storage stages. A one-entry holding register takes the next byte from the host. A shift register serialises the frame that is currently on the line. A flag shows when the holding stage is empty. The host writes a byte, and the flag clears until the transmitter takes that byte.

Each frame has these parts, in order:
- one low start bit;
- eight data bits, least significant bit first;
- an optional parity bit, even or odd;
- one or two high stop bits.

Every bit lasts a fixed number of pulses of an external baud-rate tick. The block decides what follows a frame when its last stop bit begins. If a byte is waiting, the block moves it into the shift register, and the next start bit follows the stop bit with no gap. If no byte is waiting, the block raises a transmit-end flag and holds the line high until data arrives.

Both flags drive level interrupt requests, and each request has its own enable bit. The parity and stop-bit settings are captured when a byte moves into the shift register.

Top module: `aser_tx`

## Requirements
- R1: After reset the line `txd` is 1, `hold_empty` is 1 and `tx_end` is 1.
- R2: A frame has these bits, in order:
  - a start bit of 0;
  - the data bits D0 to D7, least significant first;
  - any parity bit;
  - the stop bits, each of 1.

  Each bit lasts exactly `TICKS_PER_BIT` (16) `baud_tick` pulses, apart from the first start bit after idle. That start bit begins on the clock after the load and ends on the 16th tick that follows.
- R3: When `cfg_par_en` is 1, a parity bit follows D7. Its value is the XOR of the eight data bits when `cfg_par_odd` is 0, and the inverse of that XOR when it is 1. When `cfg_par_en` is 0, no parity bit is sent.
- R4: `cfg_two_stop` = 0 gives one stop bit, and `cfg_two_stop` = 1 gives two stop bits.
- R5: A write (`wr_en` = 1) stores `wr_data` and clears both `hold_empty` and `tx_end` on that edge. When the line is idle, the byte moves into the shift register on the next clock. At that clock `hold_empty` returns to 1 and the start bit appears.
- R6: The block checks `hold_empty` when the last stop bit of a frame begins. If it is 0, the held byte moves into the shift register and `hold_empty` becomes 1. The next start bit then begins immediately after that stop bit, so consecutive start edges are exactly one frame length apart, and `tx_end` stays 0.
- R7: If `hold_empty` is 1 when the last stop bit begins, `tx_end` becomes 1. The line then stays 1 from that stop bit until a new frame starts.
- R8: `irq_empty` is high exactly when `hold_empty` and `ien_empty` are both 1. `irq_end` is high exactly when `tx_end` and `ien_end` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse; `TICKS_PER_BIT` pulses make one bit time |
| cfg_par_en | input | 1 | 1 inserts a parity bit after D7 |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 sends two stop bits, 0 sends one |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| ien_empty | input | 1 | Enable for the holding-register-empty interrupt |
| ien_end | input | 1 | Enable for the transmit-end interrupt |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_end | output | 1 | Line has gone idle after the last frame |
| irq_empty | output | 1 | Holding-register-empty interrupt request (level) |
| irq_end | output | 1 | Transmit-end interrupt request (level) |

## Verification
A wrong sequencer state shows up on `txd` within one bit time, as a wrong sample of a data, parity or stop bit. A wrong chaining decision shows up in two ways. A gap between frames changes the distance between start edges. A stale empty flag leaves `tx_end` with the wrong value at the middle of the last stop bit. A wrong holding flag shows up on `hold_empty` and `irq_empty` on the clock after a write or a load.

// File: rtl/aser_tx_pkg.sv
package aser_tx_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } line_cfg_t;

    typedef struct packed {
        logic par_bit;
        logic par_en;
        logic two_stop;
    } frame_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input line_cfg_t c);
        frame_t f;
        f.par_bit  = parity_of(d, c.par_odd);
        f.par_en   = c.par_en;
        f.two_stop = c.two_stop;
        return f;
    endfunction

endpackage

// File: rtl/aser_tx_flags.sv
module aser_tx_flags
    import aser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer,
    input  logic              end_set,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty,
    output logic              tx_end
);

    logic [DATA_W-1:0] hold_q;
    logic              empty_q;
    logic              end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
            end
            // a host write wins over a same-cycle transfer: the new byte is pending
            if (wr_en) begin
                empty_q <= 1'b0;
            end else if (xfer) begin
                empty_q <= 1'b1;
            end
            if (wr_en) begin
                end_q <= 1'b0;
            end else if (end_set) begin
                end_q <= 1'b1;
            end
        end
    end

    assign hold_data  = hold_q;
    assign hold_empty = empty_q;
    assign tx_end     = end_q;

endmodule

// File: rtl/aser_tx_ticker.sv
module aser_tx_ticker #(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int unsigned CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_done = run && baud_tick && (cnt_q == LAST);

endmodule

// File: rtl/aser_tx_engine.sv
module aser_tx_engine
    import aser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_done,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    input  line_cfg_t         cfg,
    output logic              xfer,
    output logic              end_set,
    output logic              busy,
    output logic              txd
);

    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         st_q, st_d;
    frame_t            fr_q, fr_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              chain_q, chain_d;
    logic              last_q, last_d;
    logic              final_entry;

    always_comb begin
        st_d        = st_q;
        fr_d        = fr_q;
        sh_d        = sh_q;
        idx_d       = idx_q;
        chain_d     = chain_q;
        last_d      = last_q;
        xfer        = 1'b0;
        end_set     = 1'b0;
        final_entry = 1'b0;

        case (st_q)
            ST_IDLE: begin
                if (!hold_empty) begin
                    xfer    = 1'b1;
                    fr_d    = build_frame(hold_data, cfg);
                    sh_d    = hold_data;
                    chain_d = 1'b0;
                    st_d    = ST_START;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    idx_d = '0;
                    st_d  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    sh_d = sh_q >> 1;
                    if (idx_q == LAST_IDX) begin
                        if (fr_q.par_en) begin
                            st_d = ST_PAR;
                        end else begin
                            st_d        = ST_STOP1;
                            last_d      = !fr_q.two_stop;
                            final_entry = !fr_q.two_stop;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_done) begin
                    st_d        = ST_STOP1;
                    last_d      = !fr_q.two_stop;
                    final_entry = !fr_q.two_stop;
                end
            end
            ST_STOP1: begin
                if (bit_done) begin
                    if (!last_q) begin
                        st_d        = ST_STOP2;
                        last_d      = 1'b1;
                        final_entry = 1'b1;
                    end else begin
                        st_d = chain_q ? ST_START : ST_IDLE;
                    end
                end
            end
            ST_STOP2: begin
                if (bit_done) begin
                    st_d = chain_q ? ST_START : ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase

        // decision point: start of the frame's last stop bit
        if (final_entry) begin
            if (!hold_empty) begin
                xfer    = 1'b1;
                fr_d    = build_frame(hold_data, cfg);
                sh_d    = hold_data;
                chain_d = 1'b1;
            end else begin
                end_set = 1'b1;
                chain_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            fr_q    <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            chain_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            fr_q    <= fr_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        case (st_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh_q[0];
            ST_PAR:   txd = fr_q.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/aser_tx.sv
module aser_tx
    import aser_tx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ien_empty,
    input  logic              ien_end,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_end,
    output logic              irq_empty,
    output logic              irq_end
);

    line_cfg_t         cfg;
    logic [DATA_W-1:0] hold_data;
    logic              xfer;
    logic              end_set;
    logic              busy;
    logic              bit_done;

    assign cfg.par_en   = cfg_par_en;
    assign cfg.par_odd  = cfg_par_odd;
    assign cfg.two_stop = cfg_two_stop;

    aser_tx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .xfer       (xfer),
        .end_set    (end_set),
        .hold_data  (hold_data),
        .hold_empty (hold_empty),
        .tx_end     (tx_end)
    );

    aser_tx_ticker #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_ticker (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    aser_tx_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .bit_done   (bit_done),
        .hold_empty (hold_empty),
        .hold_data  (hold_data),
        .cfg        (cfg),
        .xfer       (xfer),
        .end_set    (end_set),
        .busy       (busy),
        .txd        (txd)
    );

    assign irq_empty = hold_empty && ien_empty;
    assign irq_end   = tx_end && ien_end;

endmodule

// File: rtl/aser_tx_chk.sv
module aser_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic ien_empty,
    input logic ien_end,
    input logic txd,
    input logic hold_empty,
    input logic tx_end,
    input logic irq_empty,
    input logic irq_end
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: the first edge after a reset cycle sees the marking state
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            a_r1_reset_marking: assert (txd && hold_empty && tx_end)
                else $error("reset state wrong");
        end
    end

    // R5: a write clears both flags on the next edge
    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!hold_empty && !tx_end));

    // R7: while transmit-end is flagged the line is marking
    a_r7_end_marks: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> txd);

    // R8: interrupt requests need their flag and enable
    a_r8_irq_empty_gate: assert property (@(posedge clk) disable iff (rst)
        irq_empty |-> (hold_empty && ien_empty));

    a_r8_irq_end_gate: assert property (@(posedge clk) disable iff (rst)
        irq_end |-> (tx_end && ien_end));

endmodule

bind aser_tx aser_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .ien_empty  (ien_empty),
    .ien_end    (ien_end),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_end     (tx_end),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end)
);

// File: tb/aser_tx_tb.sv
module aser_tx_tb;

    localparam int TICK_DIV = 4;
    localparam int TPB      = 16;
    localparam int BITC     = TPB * TICK_DIV;
    localparam int HALF     = BITC / 2;

    typedef struct {
        logic [7:0] data;
        logic       pe;
        logic       odd;
        logic       two;
        logic       last;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ien_empty = 1'b0;
    logic       ien_end = 1'b0;
    logic       txd, hold_empty, tx_end, irq_empty, irq_end;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    frames_sent = 0;
    int    frames_seen = 0;
    int    exact_cnt = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    aser_tx #(.TICKS_PER_BIT(TPB)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .baud_tick    (baud_tick),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ien_empty    (ien_empty),
        .ien_end      (ien_end),
        .txd          (txd),
        .hold_empty   (hold_empty),
        .tx_end       (tx_end),
        .irq_empty    (irq_empty),
        .irq_end      (irq_end)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: wait for room, write, push expected frame
    task automatic send(input logic [7:0] d, input logic last);
        item_t it;
        while (!hold_empty) @(negedge clk);
        it.data = d; it.pe = cfg_par_en; it.odd = cfg_par_odd;
        it.two = cfg_two_stop; it.last = last;
        exp_q.push_back(it);
        frames_sent++;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R5", "empty after write", int'(hold_empty), 0);
        chk(tx_end == 1'b0, "R5", "tx_end after write", int'(tx_end), 0);
    endtask

    task automatic wait_idle();
        while (frames_seen != frames_sent) @(negedge clk);
        repeat (BITC) @(negedge clk);
    endtask

    // monitor: decode frames at bit centres and compare with the scoreboard
    initial begin
        int prev_start = 0;
        int prev_len = 0;
        bit have_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && txd == 1'b0) begin
                item_t it;
                logic [7:0] got;
                int start_cyc;
                int nb;
                start_cyc = cyc;
                if (have_prev && (start_cyc - prev_start == prev_len)) exact_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected frame", 0, 1);
                    it.data = 8'h00; it.pe = 1'b0; it.odd = 1'b0; it.two = 1'b0; it.last = 1'b1;
                end else begin
                    it = exp_q.pop_front();
                end
                nb = 10 + int'(it.pe) + int'(it.two);
                repeat (HALF) @(negedge clk);
                chk(txd == 1'b0, "R2", "start bit", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = txd;
                end
                chk(got == it.data, "R2", "data bits", int'(got), int'(it.data));
                if (it.pe) begin
                    repeat (BITC) @(negedge clk);
                    chk(txd == ((^it.data) ^ it.odd), "R3", "parity bit",
                        int'(txd), int'((^it.data) ^ it.odd));
                end
                repeat (BITC) @(negedge clk);
                chk(txd == 1'b1, "R4", "first stop bit", int'(txd), 1);
                if (it.two) begin
                    repeat (BITC) @(negedge clk);
                    chk(txd == 1'b1, "R4", "second stop bit", int'(txd), 1);
                end
                chk(tx_end == it.last, it.last ? "R7" : "R6", "tx_end at last stop",
                    int'(tx_end), int'(it.last));
                prev_start = start_cyc;
                prev_len = nb * BITC;
                have_prev = 1'b1;
                frames_seen++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
        chk(tx_end == 1'b1, "R1", "tx_end after reset", int'(tx_end), 1);
        chk(irq_empty == 1'b0 && irq_end == 1'b0, "R8", "irqs masked",
            int'({irq_empty, irq_end}), 0);
        ien_empty = 1'b1;
        ien_end = 1'b1;
        #1;
        chk(irq_empty == 1'b1 && irq_end == 1'b1, "R8", "irqs enabled",
            int'({irq_empty, irq_end}), 3);

        // single frame from idle, 8N1 (R5 timing)
        @(negedge clk);
        send(8'hA5, 1'b1);
        chk(irq_empty == 1'b0, "R8", "irq_empty after write", int'(irq_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R5", "empty after load", int'(hold_empty), 1);
        chk(txd == 1'b0, "R5", "start bit after load", int'(txd), 0);
        wait_idle();
        chk(tx_end == 1'b1 && irq_end == 1'b1, "R7", "tx_end and irq_end idle",
            int'({tx_end, irq_end}), 3);
        begin
            bit all_high = 1'b1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd != 1'b1) all_high = 1'b0;
            end
            chk(all_high, "R7", "marking while idle", int'(all_high), 1);
        end

        // burst, even parity, two stop bits (R3, R4, R6)
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
        base = exact_cnt;
        send(8'h00, 1'b0);
        send(8'hFF, 1'b0);
        send(8'h3C, 1'b1);
        wait_idle();
        chk(exact_cnt - base >= 1, "R6", "back-to-back start spacing", exact_cnt - base, 1);

        // burst, odd parity, one stop bit
        cfg_par_odd = 1'b1; cfg_two_stop = 1'b0;
        base = exact_cnt;
        send(8'h81, 1'b0);
        send(8'h7E, 1'b0);
        send(8'h01, 1'b0);
        send(8'h55, 1'b1);
        wait_idle();
        chk(exact_cnt - base >= 2, "R6", "back-to-back start spacing", exact_cnt - base, 2);

        // no parity, two stop bits, end interrupt masked
        cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        ien_end = 1'b0;
        send(8'hC3, 1'b1);
        wait_idle();
        chk(tx_end == 1'b1 && irq_end == 1'b0, "R8", "irq_end masked",
            int'({tx_end, irq_end}), 2);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule